// File: doc/BRIEF.md
# Indexed Frame-Buffer Descriptor Table

This block holds a table of pixel-buffer descriptors that pixel engines select by a small index instead of a raw address. Each descriptor records where a buffer starts, how far apart its lines are, how many lines it has, and three small mode fields: wrap, block layout and byte order. Base address and line stride are kept in 8-byte units.

Software fills an entry in three bus writes. Two writes load a pair of staging words, and a third write to the command word names an entry and either commits the staged pair into that entry or copies that entry back into the staging words so that it can be read. A separate lookup port takes an index from a pixel engine and returns the decoded descriptor, with base and stride scaled up to byte values, one cycle later.

Top module: `fb_desc_table`

## Requirements
- R1: Synchronous active-high reset clears every table entry and both staging words to zero, so that after reset all bus reads return 0 and the lookup port returns all-zero fields.
- R2: A bus write to byte offset 0x0 loads the low staging word (all 32 bits kept). A write to offset 0x4 loads the high staging word; only bits 29:0 are kept and bits 31:30 always read as 0.
- R3: A write to the command word at offset 0x8 with bit 9 set copies the staging pair into the entry named by bits 7:0 of the written value, and the table holds the new entry from the clock edge that accepts the command.
- R4: A command with bit 8 set and bit 9 clear loads the named entry into both staging words at the clock edge that accepts the command, so that later reads of 0x0 and 0x4 return that entry.
- R5: A command with both bit 9 and bit 8 set performs only the commit. The staging words keep their values.
- R6: A command with neither bit 9 nor bit 8 set changes neither the table nor the staging words.
- R7: The lookup port registers the presented index. One cycle later it returns base in bytes = low word bits 28:0 times 8 and stride in bytes = {high bits 8:0, low bits 31:29} times 8.
- R8: The lookup port decodes the high word as height = bits 21:9, wrap = bits 23:22, block mode = bits 25:24 and endian = bits 29:26.
- R9: A read request is answered with bus_rvalid high in exactly the next cycle, and at no other time. A read of offset 0x4 issued after a commit therefore returns only once the table already holds the committed entry, so software can use it as a flush.
- R10: Reads of offset 0x8 and of unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| lk_idx | input | 8 | Descriptor index from a pixel engine |
| lk_base | output | 32 | Buffer base address in bytes |
| lk_stride | output | 15 | Line stride in bytes |
| lk_height | output | 13 | Buffer height in lines |
| lk_wrap | output | 2 | Wrap mode field |
| lk_blkmode | output | 2 | Block mode field |
| lk_endian | output | 4 | Endian field |

## Verification
The hardest case to reach is a command that carries both flags, together with one that carries neither. Either can only be told apart from a correct design if the staging words hold something that differs from the table entry being named. To get there, the stimulus first commits a known entry, then stages a different pair, and only then issues the dual-flag or no-flag command. The bench reads the staging words back over the bus and fetches the named entry through the lookup port. The stride split across the two words is exercised with values whose three low bits and nine high bits differ.

// File: rtl/fbdt_pkg.sv
package fbdt_pkg;

    localparam int WORD_W      = 32;
    localparam int BASE_W      = 29;
    localparam int STR_LO_W    = 3;
    localparam int STR_HI_W    = 9;
    localparam int STRIDE_W    = STR_LO_W + STR_HI_W;
    localparam int HEIGHT_W    = 13;
    localparam int WRAP_W      = 2;
    localparam int BLK_W       = 2;
    localparam int ENDIAN_W    = 4;
    localparam int HI_USED_W   = STR_HI_W + HEIGHT_W + WRAP_W + BLK_W + ENDIAN_W;
    localparam int UNIT_SHIFT  = 3;
    localparam int BASE_B_W    = BASE_W + UNIT_SHIFT;
    localparam int STRIDE_B_W  = STRIDE_W + UNIT_SHIFT;
    localparam int CMD_IDX_W   = 8;
    localparam int CMD_RD_BIT  = 8;
    localparam int CMD_WR_BIT  = 9;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] OFF_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_HI  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CMD = 4'h8;

    typedef struct packed {
        logic [ENDIAN_W-1:0] endian;
        logic [BLK_W-1:0]    blk;
        logic [WRAP_W-1:0]   wrap;
        logic [HEIGHT_W-1:0] height;
        logic [STRIDE_W-1:0] stride;
        logic [BASE_W-1:0]   base;
    } desc_t;

    typedef struct packed {
        logic [BASE_B_W-1:0]   base_bytes;
        logic [STRIDE_B_W-1:0] stride_bytes;
        logic [HEIGHT_W-1:0]   height;
        logic [WRAP_W-1:0]     wrap;
        logic [BLK_W-1:0]      blk;
        logic [ENDIAN_W-1:0]   endian;
    } view_t;

    function automatic desc_t pack_desc(input logic [WORD_W-1:0] lo,
                                        input logic [HI_USED_W-1:0] hi);
        desc_t d;
        d.base   = lo[BASE_W-1:0];
        d.stride = {hi[STR_HI_W-1:0], lo[WORD_W-1 -: STR_LO_W]};
        d.height = hi[STR_HI_W +: HEIGHT_W];
        d.wrap   = hi[STR_HI_W+HEIGHT_W +: WRAP_W];
        d.blk    = hi[STR_HI_W+HEIGHT_W+WRAP_W +: BLK_W];
        d.endian = hi[STR_HI_W+HEIGHT_W+WRAP_W+BLK_W +: ENDIAN_W];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] low_word(input desc_t d);
        return {d.stride[STR_LO_W-1:0], d.base};
    endfunction

    function automatic logic [HI_USED_W-1:0] high_word(input desc_t d);
        return {d.endian, d.blk, d.wrap, d.height, d.stride[STRIDE_W-1:STR_LO_W]};
    endfunction

    function automatic view_t to_view(input desc_t d);
        view_t v;
        v.base_bytes   = {d.base, {UNIT_SHIFT{1'b0}}};
        v.stride_bytes = {d.stride, {UNIT_SHIFT{1'b0}}};
        v.height       = d.height;
        v.wrap         = d.wrap;
        v.blk          = d.blk;
        v.endian       = d.endian;
        return v;
    endfunction

endpackage

// File: rtl/fbdt_regs.sv
module fbdt_regs
    import fbdt_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    output logic                 cmt_en,
    output logic [IDX_W-1:0]     cmt_idx,
    output desc_t                cmt_desc,
    output logic [IDX_W-1:0]     ld_idx,
    input  desc_t                ld_desc
);

    logic [WORD_W-1:0]    stg_lo;
    logic [HI_USED_W-1:0] stg_hi;
    logic                 wr_acc, rd_acc;
    logic                 wr_lo, wr_hi, wr_cmd, ld_en;
    logic [WORD_W-1:0]    rd_mux;

    assign wr_acc = bus_req && bus_we;
    assign rd_acc = bus_req && !bus_we;
    assign wr_lo  = wr_acc && (bus_addr == OFF_LO);
    assign wr_hi  = wr_acc && (bus_addr == OFF_HI);
    assign wr_cmd = wr_acc && (bus_addr == OFF_CMD);

    // commit wins over load when both flags are present
    assign cmt_en   = wr_cmd && bus_wdata[CMD_WR_BIT];
    assign ld_en    = wr_cmd && bus_wdata[CMD_RD_BIT] && !bus_wdata[CMD_WR_BIT];
    assign cmt_idx  = bus_wdata[IDX_W-1:0];
    assign ld_idx   = bus_wdata[IDX_W-1:0];
    assign cmt_desc = pack_desc(stg_lo, stg_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_lo <= '0;
            stg_hi <= '0;
        end else if (wr_lo) begin
            stg_lo <= bus_wdata;
        end else if (wr_hi) begin
            stg_hi <= bus_wdata[HI_USED_W-1:0];
        end else if (ld_en) begin
            stg_lo <= low_word(ld_desc);
            stg_hi <= high_word(ld_desc);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_LO)      rd_mux = stg_lo;
        else if (bus_addr == OFF_HI) rd_mux = {{(WORD_W-HI_USED_W){1'b0}}, stg_hi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_acc;
            bus_rdata  <= rd_acc ? rd_mux : '0;
        end
    end

    // R9
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> bus_rvalid);

    // R9
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> !bus_rvalid);

    // R5
    priority_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && bus_wdata[CMD_WR_BIT] && bus_wdata[CMD_RD_BIT])
            |=> ($stable(stg_lo) && $stable(stg_hi)));

    // R6
    idle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !bus_wdata[CMD_WR_BIT] && !bus_wdata[CMD_RD_BIT])
            |=> ($stable(stg_lo) && $stable(stg_hi)));

endmodule

// File: rtl/fbdt_store.sv
module fbdt_store
    import fbdt_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc,
    input  logic [IDX_W-1:0] lk_idx,
    output desc_t            lk_desc
);

    desc_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_desc;
        end
    end

    assign rd_desc = mem[rd_idx];
    assign lk_desc = mem[lk_idx];

    // R3
    commit_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_desc)));

endmodule

// File: rtl/fbdt_lookup.sv
module fbdt_lookup
    import fbdt_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] idx_q,
    input  desc_t            desc,
    output view_t            view
);

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_in;
    end

    assign view = to_view(desc);

endmodule

// File: rtl/fb_desc_table.sv
module fb_desc_table
    import fbdt_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic [IDX_W-1:0]      lk_idx,
    output logic [BASE_B_W-1:0]   lk_base,
    output logic [STRIDE_B_W-1:0] lk_stride,
    output logic [HEIGHT_W-1:0]   lk_height,
    output logic [WRAP_W-1:0]     lk_wrap,
    output logic [BLK_W-1:0]      lk_blkmode,
    output logic [ENDIAN_W-1:0]   lk_endian
);

    logic             cmt_en;
    logic [IDX_W-1:0] cmt_idx, ld_idx, lk_idx_q;
    desc_t            cmt_desc, ld_desc, lk_desc;
    view_t            view;

    fbdt_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cmt_en(cmt_en), .cmt_idx(cmt_idx), .cmt_desc(cmt_desc),
        .ld_idx(ld_idx), .ld_desc(ld_desc)
    );

    fbdt_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(cmt_en), .wr_idx(cmt_idx), .wr_desc(cmt_desc),
        .rd_idx(ld_idx), .rd_desc(ld_desc),
        .lk_idx(lk_idx_q), .lk_desc(lk_desc)
    );

    fbdt_lookup #(.IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst(rst),
        .idx_in(lk_idx), .idx_q(lk_idx_q),
        .desc(lk_desc), .view(view)
    );

    assign lk_base    = view.base_bytes;
    assign lk_stride  = view.stride_bytes;
    assign lk_height  = view.height;
    assign lk_wrap    = view.wrap;
    assign lk_blkmode = view.blk;
    assign lk_endian  = view.endian;

endmodule

// File: tb/test_fb_desc_table.sv
module test_fb_desc_table;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {index, low word, high word}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h00, 32'h0000_0001, 32'h0000_0000},
        {8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {8'h10, 32'hA000_1234, 32'h1234_5678},
        {8'h80, 32'h2000_0000, 32'h0400_0200},
        {8'h01, 32'h1FFF_FFFF, 32'h0140_0000},
        {8'h7F, 32'h5555_5555, 32'h2AAA_AAAA}
    };

    logic        clk = 0, rst = 1;
    logic        bus_req = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  lk_idx = 0;
    logic [31:0] lk_base;
    logic [14:0] lk_stride;
    logic [12:0] lk_height;
    logic [1:0]  lk_wrap, lk_blkmode;
    logic [3:0]  lk_endian;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_desc_table i_fb_desc_table (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lk_idx(lk_idx), .lk_base(lk_base),
        .lk_stride(lk_stride), .lk_height(lk_height), .lk_wrap(lk_wrap),
        .lk_blkmode(lk_blkmode), .lk_endian(lk_endian)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        chk("R9 rvalid", {63'd0, bus_rvalid}, 64'd1);
        d = bus_rdata;
        @(negedge clk);
        chk("R9 rvalid drop", {63'd0, bus_rvalid}, 64'd0);
    endtask

    task automatic look(input logic [7:0] idx);
        @(negedge clk);
        lk_idx = idx;
        @(negedge clk);
    endtask

    task automatic chk_entry(input string req, input logic [31:0] lo, input logic [31:0] hi);
        chk({req, " R7 base"},   {32'd0, lk_base},   {32'd0, lo[28:0], 3'b000});
        chk({req, " R7 stride"}, {49'd0, lk_stride}, {49'd0, hi[8:0], lo[31:29], 3'b000});
        chk({req, " R8 height"}, {51'd0, lk_height}, {51'd0, hi[21:9]});
        chk({req, " R8 wrap"},   {62'd0, lk_wrap},   {62'd0, hi[23:22]});
        chk({req, " R8 blk"},    {62'd0, lk_blkmode},{62'd0, hi[25:24]});
        chk({req, " R8 endian"}, {60'd0, lk_endian}, {60'd0, hi[29:26]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(4'h0, d); chk("R1 lo after reset", {32'd0, d}, 64'd0);
        rd(4'h4, d); chk("R1 hi after reset", {32'd0, d}, 64'd0);
        look(8'h10); chk_entry("R1 reset entry", 32'd0, 32'd0);

        // vector walk: R2 staging, R3 commit, R9 flush read, R7/R8 lookup
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  ix;
            logic [31:0] lo, hi;
            {ix, lo, hi} = VEC[v];
            wr(4'h0, lo);
            wr(4'h4, hi);
            rd(4'h0, d); chk("R2 lo staging", {32'd0, d}, {32'd0, lo});
            wr(4'h8, 32'h200 | {24'd0, ix});
            rd(4'h4, d); chk("R2 hi staging masked", {32'd0, d}, {32'd0, 2'b00, hi[29:0]});
            look(ix); chk_entry("R3 committed", lo, hi);
        end
        look(8'h00); chk_entry("R3 entry kept", 32'h0000_0001, 32'h0);

        // R4 load back into staging
        wr(4'h0, 32'hDEAD_BEEF);
        wr(4'h4, 32'h0000_0003);
        wr(4'h8, 32'h0000_0110);
        rd(4'h0, d); chk("R4 load lo", {32'd0, d}, 64'hA000_1234);
        rd(4'h4, d); chk("R4 load hi", {32'd0, d}, 64'h1234_5678);
        wr(4'h8, 32'h0000_01FF);
        rd(4'h4, d); chk("R4 load hi masked", {32'd0, d}, 64'h3FFF_FFFF);

        // R5 both flags: commit only
        wr(4'h0, 32'h1111_1111);
        wr(4'h4, 32'h0222_2222);
        wr(4'h8, 32'h0000_0320);
        rd(4'h0, d); chk("R5 staging lo kept", {32'd0, d}, 64'h1111_1111);
        rd(4'h4, d); chk("R5 staging hi kept", {32'd0, d}, 64'h0222_2222);
        look(8'h20); chk_entry("R5 commit done", 32'h1111_1111, 32'h0222_2222);

        // R6 no flags: nothing changes
        wr(4'h8, 32'h0000_0030);
        wr(4'h8, 32'h0000_0010);
        rd(4'h0, d); chk("R6 staging lo kept", {32'd0, d}, 64'h1111_1111);
        look(8'h30); chk_entry("R6 entry untouched", 32'd0, 32'd0);
        look(8'h10); chk_entry("R6 entry kept", 32'hA000_1234, 32'h1234_5678);

        // R10 command and unmapped offsets
        rd(4'h8, d); chk("R10 cmd reads zero", {32'd0, d}, 64'd0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); chk("R10 unmapped reads zero", {32'd0, d}, 64'd0);
        rd(4'h0, d); chk("R10 unmapped write ignored", {32'd0, d}, 64'h1111_1111);

        // R1 reset clears everything
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        rd(4'h0, d); chk("R1 lo cleared", {32'd0, d}, 64'd0);
        rd(4'h4, d); chk("R1 hi cleared", {32'd0, d}, 64'd0);
        look(8'hFF); chk_entry("R1 entry cleared", 32'd0, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule